// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Separated Error Status

This block receives asynchronous serial characters on a single input line. It oversamples the line with a tick input that the surrounding logic provides, and it assembles frames of `DATA_W` bits, least significant bit first. A parity bit, even or odd, may follow the data bits, and one stop bit closes the frame. A small register bus gives access to a control byte, a status byte and the received character.

A frame that arrives without errors sets a data-ready flag. That flag drives `rx_full_req`, a level request that a DMA or transfer engine can service. A frame with a parity or stop-bit problem takes a different path. It sets only the matching error flags, which can raise the separate `rx_err_irq` line, and it never raises the data request.

Software clears a flag in two steps. It first reads the status byte while the flag is 1, then writes 0 to that bit. The error flags hold their value when reception is disabled. A line held low (a break) sets the stop-bit error again on every frame time. The synchronized line level can be read in the status byte, so software can confirm a break.

Top module: `uart_rx_stat`

## Requirements
- R1: A well-formed frame, with the start bit low, `DATA_W` data bits LSB first, the optional parity bit and a high stop bit, each sampled at the middle of its `OVS` ticks, is stored in the data register (address 2). It sets status bit 0 (ready), which is seen on `rx_full_req`.
- R2: With control bit 1 set, a parity bit follows the data. Control bit 2 selects odd parity (1) or even parity (0). A mismatch sets status bit 2 and leaves the ready flag and the data register unchanged.
- R3: A low stop bit sets status bit 3. The ready flag and the data register stay unchanged, and `rx_full_req` is not raised by that frame.
- R4: `rx_err_irq` is high exactly when control bit 3 is set and at least one of status bits 1, 2 or 3 is set. With control bit 3 clear, errors leave it low.
- R5: When the line stays low, reception continues. Each frame time sets status bit 3 again, even after software has cleared it.
- R6: A frame that completes while the ready flag is set raises status bit 1 (overrun). The earlier character stays in the data register.
- R7: A status flag clears only on a write of 0 to its bit at address 1 after a read of address 1 has returned it as 1. A write of 0 with no such read, or a write of 1, leaves it set.
- R8: Control bit 0 enables reception. Clearing it leaves status bits 1 to 3 unchanged, and while it is clear no frame is received.
- R9: Status bit 7 returns the line level after a two-flop synchronizer.
- R10: A start bit is taken from a high-to-low transition and confirmed at its middle. A low pulse shorter than half a bit starts no frame.
- R11: After reset, the control, status (bits 0 to 3) and data registers read 0, and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling strobe, OVS per bit |
| rxd | input | 1 | Serial receive line |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| rx_full_req | output | 1 | Received-character-ready request |
| rx_err_irq | output | 1 | Receive-error interrupt request |

## Verification
The bench uses the default 8 data bits and 16 ticks per bit. It drives the tick on every second clock, so one bit lasts 32 clocks. That spacing makes the mid-bit sampling point distinct from the tick rate, and it leaves room for a sub-half-bit glitch of 4 clocks and a long break spanning several frame times.

// File: rtl/uart_rx_stat.sv
module uart_rx_stat #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rx_full_req,
  output logic       rx_err_irq
);
  localparam int CW = $clog2(OVS);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_e;
  st_e st;

  logic [1:0]        sync;
  logic              rx_s, line_q, brk, par_q;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] sh, data_q;
  logic [7:0]        ctrl_q;
  logic [3:0]        flags, seen, clr, set;

  wire rx_en   = ctrl_q[0];
  wire par_en  = ctrl_q[1];
  wire par_odd = ctrl_q[2];
  wire irq_en  = ctrl_q[3];
  assign rx_s = sync[1];

  wire fin      = rx_en && tick && (st == S_STOP) && (cnt == LAST);
  wire ferr_now = !rx_s;
  wire perr_now = par_en && (par_q != ((^sh) ^ par_odd));
  wire rd_stat  = bus_sel && !bus_wr && (bus_addr == 2'd1);
  wire wr_stat  = bus_sel &&  bus_wr && (bus_addr == 2'd1);
  wire wr_ctrl  = bus_sel &&  bus_wr && (bus_addr == 2'd0);

  assign set = {fin && ferr_now, fin && perr_now, fin && flags[0],
                fin && !ferr_now && !perr_now && !flags[0]};
  assign clr = {4{wr_stat}} & seen & ~bus_wdata[3:0];

  assign rx_full_req = flags[0];
  assign rx_err_irq  = irq_en && (|flags[3:1]);

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = ctrl_q;
      2'd1:    bus_rdata = {rx_s, 3'b000, flags};
      2'd2:    bus_rdata = 8'(data_q);
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; sh <= '0;
      par_q <= 1'b0; line_q <= 1'b1; brk <= 1'b0;
    end else begin
      if (tick) line_q <= rx_s;
      if (!rx_en) begin
        st <= S_IDLE; brk <= 1'b0; cnt <= '0;
      end else if (tick) begin
        case (st)
          S_IDLE:
            if (brk) begin
              if (rx_s) begin brk <= 1'b0; cnt <= '0; end
              else if (cnt == MID) begin st <= S_START; cnt <= '0; brk <= 1'b0; end
              else cnt <= cnt + 1'b1;
            end else if (line_q && !rx_s) begin
              st <= S_START; cnt <= '0;
            end
          S_START:
            if (cnt == MID) begin
              cnt <= '0; bitn <= '0;
              st  <= rx_s ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          S_DATA:
            if (cnt == LAST) begin
              cnt <= '0;
              sh  <= {rx_s, sh[DATA_W-1:1]};
              if (bitn == BW'(DATA_W - 1)) st <= par_en ? S_PAR : S_STOP;
              else bitn <= bitn + 1'b1;
            end else cnt <= cnt + 1'b1;
          S_PAR:
            if (cnt == LAST) begin
              cnt <= '0; par_q <= rx_s; st <= S_STOP;
            end else cnt <= cnt + 1'b1;
          default:
            if (cnt == LAST) begin
              cnt <= '0; st <= S_IDLE; brk <= !rx_s;
            end else cnt <= cnt + 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; flags <= '0; seen <= '0; data_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      flags <= (flags & ~clr) | set;
      seen  <= (seen & ~clr & ~set) | (rd_stat ? flags : 4'b0);
      if (set[0]) data_q <= sh;
    end
  end

  p_good_sets_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !ferr_now && !perr_now && !flags[0]) |=> rx_full_req);
  p_err_no_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && (ferr_now || perr_now) && !flags[0]) |=> !rx_full_req);
  p_irq_on_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && ferr_now && irq_en && !wr_ctrl) |=> rx_err_irq);
  p_ovr_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && flags[0]) |=> (flags[1] && $stable(data_q)));
  p_w1_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[3] && flags[3]) |=> flags[3]);
  p_disable_keeps_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[0] && !fin) |=> $stable(flags[3:1]));
endmodule

// File: tb/uart_rx_stat_bench.sv
module uart_rx_stat_bench;
  localparam int BT = 32;
  localparam logic [11:0] VEC [7] = '{
    {8'hA5, 4'b0001}, {8'h3C, 4'b1001}, {8'h81, 4'b1101}, {8'h5A, 4'b1011},
    {8'hFF, 4'b0000}, {8'h00, 4'b1110}, {8'h7E, 4'b1101}};

  logic clk = 0, rst_n = 0, tick = 0, rxd = 1;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, rd;
  logic rx_full_req, rx_err_irq;
  int checks = 0, fails = 0;
  logic [7:0] prev = 8'h00;

  uart_rx_stat u_uart_rx_stat (.clk, .rst_n, .tick, .rxd, .bus_sel, .bus_wr,
    .bus_addr, .bus_wdata, .bus_rdata, .rx_full_req, .rx_err_irq);

  always #5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic clear_all();
    logic [7:0] t;
    bus_read(2'd1, t);
    bus_write(2'd1, 8'h00);
  endtask

  task automatic send(logic [7:0] d, logic pen, logic pbit, logic stop);
    @(negedge clk); rxd = 0; repeat (BT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (BT) @(negedge clk); end
    if (pen) begin rxd = pbit; repeat (BT) @(negedge clk); end
    rxd = stop; repeat (BT) @(negedge clk);
    rxd = 1; repeat (BT) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    bus_read(2'd0, rd); chk("R11 ctrl", rd, 8'h00);
    bus_read(2'd1, rd); chk("R11 status", rd & 8'h0F, 8'h00);
    bus_read(2'd2, rd); chk("R11 data", rd, 8'h00);
    chk("R11 outputs", {6'b0, rx_full_req, rx_err_irq}, 8'h00);

    // R1 R2 R3 R4 vector table
    for (int v = 0; v < 7; v++) begin
      logic [7:0] d; logic pen, odd, bad, stop, pbit, perr, ferr, ok;
      {d, pen, odd, bad, stop} = VEC[v];
      pbit = (odd ? ~^d : ^d) ^ bad;
      perr = pen && bad; ferr = !stop; ok = !perr && !ferr;
      clear_all();
      bus_write(2'd0, {4'b0, 1'b1, odd, pen, 1'b1});
      send(d, pen, pbit, stop);
      if (ok) prev = d;
      bus_read(2'd1, rd);
      chk("R1 R2 R3 status", rd & 8'h0F, {4'b0, ferr, perr, 1'b0, ok});
      bus_read(2'd2, rd); chk("R1 R2 R3 data", rd, prev);
      chk("R1 R3 full_req", {7'b0, rx_full_req}, {7'b0, ok});
      chk("R4 err_irq", {7'b0, rx_err_irq}, {7'b0, !ok});
    end

    // R4 irq gated by enable
    clear_all();
    bus_write(2'd0, 8'h01);
    send(8'h11, 0, 0, 0);
    chk("R4 irq masked", {7'b0, rx_err_irq}, 8'h00);

    // R7 write 0 without a prior read leaves the flag
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, rd); chk("R7 no read", rd & 8'h08, 8'h08);
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, rd); chk("R7 write one", rd & 8'h08, 8'h08);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, rd); chk("R7 read then zero", rd & 8'h08, 8'h00);

    // R8 disabling keeps errors, blocks reception
    bus_write(2'd0, 8'h01);
    send(8'h22, 0, 0, 0);
    bus_write(2'd0, 8'h00);
    bus_read(2'd1, rd); chk("R8 ferr kept", rd & 8'h08, 8'h08);
    clear_all();
    send(8'h33, 0, 0, 1);
    bus_read(2'd1, rd); chk("R8 no rx when off", rd & 8'h0F, 8'h00);

    // R9 line level
    @(negedge clk); rxd = 0; repeat (3) @(negedge clk);
    bus_read(2'd1, rd); chk("R9 line low", rd & 8'h80, 8'h00);
    rxd = 1; repeat (3) @(negedge clk);
    bus_read(2'd1, rd); chk("R9 line high", rd & 8'h80, 8'h80);

    // R10 short glitch
    bus_write(2'd0, 8'h01);
    @(negedge clk); rxd = 0; repeat (4) @(negedge clk); rxd = 1;
    repeat (12 * BT) @(negedge clk);
    bus_read(2'd1, rd); chk("R10 glitch", rd & 8'h0F, 8'h00);

    // R6 overrun
    send(8'hA5, 0, 0, 1);
    send(8'h3C, 0, 0, 1);
    bus_read(2'd1, rd); chk("R6 overrun flags", rd & 8'h0F, 8'h03);
    bus_read(2'd2, rd); chk("R6 data kept", rd, 8'hA5);
    clear_all();

    // R5 held break
    bus_write(2'd0, 8'h09);
    @(negedge clk); rxd = 0;
    repeat (12 * BT) @(negedge clk);
    bus_read(2'd1, rd); chk("R5 break ferr", rd & 8'h89, 8'h08);
    clear_all();
    bus_read(2'd1, rd); chk("R5 cleared", rd & 8'h08, 8'h00);
    repeat (12 * BT) @(negedge clk);
    bus_read(2'd1, rd); chk("R5 ferr again", rd & 8'h08, 8'h08);
    chk("R5 irq", {7'b0, rx_err_irq}, 8'h01);
    rxd = 1;
    repeat (14 * BT) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule